// File: doc/BRIEF.md
# PS/2 Host Controller Register Block

This block is the host-facing register layer of a two-channel PS/2 controller. One channel serves a keyboard and the other an auxiliary pointing device. A byte-wide bus reaches the block through two addresses. The data port (`bus_cmd` = 0) carries received bytes on reads and outgoing bytes on writes. The command/status port (`bus_cmd` = 1) returns a status byte on reads and accepts controller commands on writes.

Each channel keeps a small receive FIFO. That FIFO is filled by the serial link below the block and by replies the controller makes up itself. Some commands only arm a one-byte pending-command latch. The next data-port write is then steered to the mode register, the output-port strobe, one of the two receive queues, or the auxiliary device. Keyboard data has priority over auxiliary data for the shared output-buffer-full flag, for the data-port read and for the interrupts.

Top module: `ps2_hostreg`

## Requirements
- R1: After reset the status byte reads 0x18 (bit 3 and bit 4 set), the mode byte reads 0x03, both FIFOs are empty and both interrupt lines are low.
- R2: Command 0x20 queues the current mode byte into the keyboard FIFO. Command 0xAA sets status bit 2 and queues 0x55. Commands 0xA9 and 0xAB each queue 0x00. Command 0xC0 queues 0x80. All of these replies go to the keyboard FIFO.
- R3: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 only arm the pending latch. The following data-port write goes, respectively, to the mode register, to a one-cycle `outp_wr_valid` strobe, into the keyboard FIFO, into the auxiliary FIFO, or to a one-cycle `aux_tx_valid` strobe. After any data-port write the latch is cleared.
- R4: A data-port write with the latch clear raises `kb_tx_valid` with the written byte for exactly the one cycle after the write.
- R5: Commands 0xA7 and 0xA8 set and clear mode bit 5. Commands 0xAD and 0xAE set and clear mode bit 4, and the keyboard interrupt follows the new value in the next cycle.
- R6: Status bit 0 is set while either FIFO holds data. Status bit 5 is set only while the auxiliary FIFO alone holds data. Bit 3 is set by a command write and cleared by a data write. Bit 4 is always 1. Bits 1, 6 and 7 are always 0.
- R7: `kb_irq` is high while the keyboard FIFO holds data, mode bit 0 is set and mode bit 4 is clear. `aux_irq` is high while only the auxiliary FIFO holds data and mode bit 1 is set.
- R8: A data-port read returns and removes the auxiliary head byte only when the auxiliary FIFO alone holds data. Otherwise it returns and removes the keyboard head byte. With both FIFOs empty it returns 0x00. Status reads change nothing.
- R9: A command code outside the recognised set changes no state, leaves the pending latch as it was, and produces no strobe.
- R10: Each FIFO holds DEPTH bytes (16 by default) in arrival order. Bytes arriving while it is full are dropped.
- R11: A device byte and a controller reply can reach the same FIFO in the same cycle. The device byte is stored first and the reply second. When only one slot is free, only the device byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe (a data-port read pops a byte) |
| bus_cmd | input | 1 | Port select: 1 = command/status, 0 = data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (status byte or selected FIFO head) |
| kb_rx_valid | input | 1 | Keyboard link delivers a byte |
| kb_rx_data | input | 8 | Byte from the keyboard link |
| aux_rx_valid | input | 1 | Auxiliary link delivers a byte |
| aux_rx_data | input | 8 | Byte from the auxiliary link |
| kb_tx_valid | output | 1 | One-cycle strobe: byte for the keyboard device |
| kb_tx_data | output | 8 | Byte for the keyboard device |
| aux_tx_valid | output | 1 | One-cycle strobe: byte for the auxiliary device |
| aux_tx_data | output | 8 | Byte for the auxiliary device |
| outp_wr_valid | output | 1 | One-cycle strobe: new output-port value |
| outp_wr_data | output | 8 | Output-port value |
| kb_irq | output | 1 | Keyboard interrupt level |
| aux_irq | output | 1 | Auxiliary interrupt level |

## Verification
Two things can hit the keyboard FIFO in the same cycle: a byte from the keyboard link and a reply produced by a controller command. The bench raises `kb_rx_valid` in the same cycle as a 0xAA command write. It then reads the FIFO back and expects the link byte before 0x55. The same collision is repeated with only one free slot, and there the reply must be dropped while the link byte survives. A second overlap is keyboard and auxiliary data pending together. That case is judged on status bit 5, on the interrupt pair and on the order of the data-port reads.

// File: rtl/ps2h_pkg.sv
package ps2h_pkg;

  localparam int unsigned BYTE_W = 8;

  // controller command codes
  localparam logic [7:0] OP_NONE      = 8'h00;
  localparam logic [7:0] OP_RD_MODE   = 8'h20;
  localparam logic [7:0] OP_WR_MODE   = 8'h60;
  localparam logic [7:0] OP_AUX_OFF   = 8'hA7;
  localparam logic [7:0] OP_AUX_ON    = 8'hA8;
  localparam logic [7:0] OP_AUX_TEST  = 8'hA9;
  localparam logic [7:0] OP_SELF_TEST = 8'hAA;
  localparam logic [7:0] OP_KB_TEST   = 8'hAB;
  localparam logic [7:0] OP_KB_OFF    = 8'hAD;
  localparam logic [7:0] OP_KB_ON     = 8'hAE;
  localparam logic [7:0] OP_RD_INPUT  = 8'hC0;
  localparam logic [7:0] OP_WR_OUTP   = 8'hD1;
  localparam logic [7:0] OP_WR_KBQ    = 8'hD2;
  localparam logic [7:0] OP_WR_AUXQ   = 8'hD3;
  localparam logic [7:0] OP_WR_AUXDEV = 8'hD4;

  // reply bytes
  localparam logic [7:0] RPL_TEST_OK  = 8'h00;
  localparam logic [7:0] RPL_SELF_OK  = 8'h55;
  localparam logic [7:0] RPL_INPUT    = 8'h80;

  // mode register fields
  localparam int unsigned MB_KB_IE   = 0;
  localparam int unsigned MB_AUX_IE  = 1;
  localparam int unsigned MB_KB_OFF  = 4;
  localparam int unsigned MB_AUX_OFF = 5;
  localparam logic [7:0]  MODE_RST   = 8'h03;

  // channel indices
  localparam int unsigned CH_KB  = 0;
  localparam int unsigned CH_AUX = 1;
  localparam int unsigned N_CH   = 2;

  typedef struct packed {
    logic       vld;
    logic [7:0] dat;
  } byte_evt_t;

endpackage

// File: rtl/ps2h_fifo.sv
module ps2h_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         dev_push,
  input  logic [W-1:0]                 dev_byte,
  input  logic                         ctl_push,
  input  logic [W-1:0]                 ctl_byte,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d, room;
  logic          take_dev, take_ctl, take_pop;
  logic [AW-1:0] slot_dev, slot_ctl;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    room     = CW'(DEPTH) - cnt_q;
    take_dev = dev_push && (room != '0);
    take_ctl = ctl_push && (room > {{(CW-1){1'b0}}, take_dev});
    take_pop = pop && (cnt_q != '0);
    slot_dev = wptr_q;
    slot_ctl = take_dev ? bump(wptr_q) : wptr_q;
    wptr_d   = wptr_q;
    if (take_dev && take_ctl) wptr_d = bump(bump(wptr_q));
    else if (take_dev || take_ctl) wptr_d = bump(wptr_q);
    rptr_d   = take_pop ? bump(rptr_q) : rptr_q;
    cnt_d    = cnt_q + {{(CW-1){1'b0}}, take_dev} + {{(CW-1){1'b0}}, take_ctl}
                     - {{(CW-1){1'b0}}, take_pop};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take_dev) mem[slot_dev] <= dev_byte;
    if (take_ctl) mem[slot_ctl] <= ctl_byte;
  end

  assign head  = mem[rptr_q];
  assign level = cnt_q;

endmodule

// File: rtl/ps2h_ctrl.sv
module ps2h_ctrl
  import ps2h_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_cmd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] mode,
  output logic       selftest,
  output logic       cmdflag,
  output byte_evt_t  kb_reply,
  output byte_evt_t  aux_reply,
  output byte_evt_t  kb_tx,
  output byte_evt_t  aux_tx,
  output byte_evt_t  outp_wr
);
  logic [7:0] mode_q, mode_d, latch_q, latch_d;
  logic       st_q, st_d, cf_q, cf_d;
  byte_evt_t  kbtx_q, kbtx_d, auxtx_q, auxtx_d, outp_q, outp_d;
  logic       cmd_wr, dat_wr;

  assign cmd_wr = bus_wr && bus_cmd;
  assign dat_wr = bus_wr && !bus_cmd;

  always_comb begin
    mode_d    = mode_q;
    latch_d   = latch_q;
    st_d      = st_q;
    cf_d      = cf_q;
    kb_reply  = '{vld: 1'b0, dat: bus_wdata};
    aux_reply = '{vld: 1'b0, dat: bus_wdata};
    kbtx_d    = '{vld: 1'b0, dat: kbtx_q.dat};
    auxtx_d   = '{vld: 1'b0, dat: auxtx_q.dat};
    outp_d    = '{vld: 1'b0, dat: outp_q.dat};
    if (cmd_wr) begin
      cf_d = 1'b1;
      case (bus_wdata)
        OP_RD_MODE:   kb_reply = '{vld: 1'b1, dat: mode_q};
        OP_WR_MODE, OP_WR_OUTP, OP_WR_KBQ, OP_WR_AUXQ, OP_WR_AUXDEV:
                      latch_d = bus_wdata;
        OP_AUX_OFF:   mode_d[MB_AUX_OFF] = 1'b1;
        OP_AUX_ON:    mode_d[MB_AUX_OFF] = 1'b0;
        OP_KB_OFF:    mode_d[MB_KB_OFF]  = 1'b1;
        OP_KB_ON:     mode_d[MB_KB_OFF]  = 1'b0;
        OP_AUX_TEST, OP_KB_TEST:
                      kb_reply = '{vld: 1'b1, dat: RPL_TEST_OK};
        OP_SELF_TEST: begin
          st_d     = 1'b1;
          kb_reply = '{vld: 1'b1, dat: RPL_SELF_OK};
        end
        OP_RD_INPUT:  kb_reply = '{vld: 1'b1, dat: RPL_INPUT};
        default:      ;
      endcase
    end
    if (dat_wr) begin
      cf_d    = 1'b0;
      latch_d = OP_NONE;
      case (latch_q)
        OP_NONE:      kbtx_d    = '{vld: 1'b1, dat: bus_wdata};
        OP_WR_MODE:   mode_d    = bus_wdata;
        OP_WR_OUTP:   outp_d    = '{vld: 1'b1, dat: bus_wdata};
        OP_WR_KBQ:    kb_reply  = '{vld: 1'b1, dat: bus_wdata};
        OP_WR_AUXQ:   aux_reply = '{vld: 1'b1, dat: bus_wdata};
        OP_WR_AUXDEV: auxtx_d   = '{vld: 1'b1, dat: bus_wdata};
        default:      ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_RST;
      latch_q <= OP_NONE;
      st_q    <= 1'b0;
      cf_q    <= 1'b1;
      kbtx_q  <= '0;
      auxtx_q <= '0;
      outp_q  <= '0;
    end else begin
      mode_q  <= mode_d;
      latch_q <= latch_d;
      st_q    <= st_d;
      cf_q    <= cf_d;
      kbtx_q  <= kbtx_d;
      auxtx_q <= auxtx_d;
      outp_q  <= outp_d;
    end
  end

  assign mode     = mode_q;
  assign selftest = st_q;
  assign cmdflag  = cf_q;
  assign kb_tx    = kbtx_q;
  assign aux_tx   = auxtx_q;
  assign outp_wr  = outp_q;

endmodule

// File: rtl/ps2h_rdsel.sv
module ps2h_rdsel
  import ps2h_pkg::*;
#(
  parameter int unsigned CW = 5
) (
  input  logic          bus_rd,
  input  logic          bus_cmd,
  input  logic [CW-1:0] kb_level,
  input  logic [CW-1:0] aux_level,
  input  logic [7:0]    kb_head,
  input  logic [7:0]    aux_head,
  input  logic [7:0]    mode,
  input  logic          selftest,
  input  logic          cmdflag,
  output logic [7:0]    status,
  output logic [7:0]    rdata,
  output logic          kb_pop,
  output logic          aux_pop,
  output logic          kb_irq,
  output logic          aux_irq
);
  logic kb_has, aux_has, aux_only, data_rd;

  always_comb begin
    kb_has   = (kb_level != '0);
    aux_has  = (aux_level != '0);
    aux_only = aux_has && !kb_has;
    data_rd  = bus_rd && !bus_cmd;
    status   = {2'b00, aux_only, 1'b1, cmdflag, selftest, 1'b0, kb_has || aux_has};
    if (bus_cmd)       rdata = status;
    else if (aux_only) rdata = aux_head;
    else if (kb_has)   rdata = kb_head;
    else               rdata = 8'h00;
    kb_pop  = data_rd && kb_has;
    aux_pop = data_rd && aux_only;
    kb_irq  = kb_has && mode[MB_KB_IE] && !mode[MB_KB_OFF];
    aux_irq = aux_only && mode[MB_AUX_IE];
  end

endmodule

// File: rtl/ps2_hostreg.sv
module ps2_hostreg
  import ps2h_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       bus_cmd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       kb_rx_valid,
  input  logic [7:0] kb_rx_data,
  input  logic       aux_rx_valid,
  input  logic [7:0] aux_rx_data,
  output logic       kb_tx_valid,
  output logic [7:0] kb_tx_data,
  output logic       aux_tx_valid,
  output logic [7:0] aux_tx_data,
  output logic       outp_wr_valid,
  output logic [7:0] outp_wr_data,
  output logic       kb_irq,
  output logic       aux_irq
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic [7:0] mode_w, status_w;
  logic       selftest_w, cmdflag_w;
  byte_evt_t  kb_reply_w, aux_reply_w, kb_tx_w, aux_tx_w, outp_w;

  logic [N_CH-1:0]         dev_push, ctl_push, pop;
  logic [N_CH-1:0][7:0]    dev_byte, ctl_byte, head;
  logic [N_CH-1:0][CW-1:0] level;
  logic [CW-1:0]           kb_level_w, aux_level_w;

  ps2h_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_wr    (bus_wr),
    .bus_cmd   (bus_cmd),
    .bus_wdata (bus_wdata),
    .mode      (mode_w),
    .selftest  (selftest_w),
    .cmdflag   (cmdflag_w),
    .kb_reply  (kb_reply_w),
    .aux_reply (aux_reply_w),
    .kb_tx     (kb_tx_w),
    .aux_tx    (aux_tx_w),
    .outp_wr   (outp_w)
  );

  assign dev_push[CH_KB]  = kb_rx_valid;
  assign dev_byte[CH_KB]  = kb_rx_data;
  assign dev_push[CH_AUX] = aux_rx_valid;
  assign dev_byte[CH_AUX] = aux_rx_data;
  assign ctl_push[CH_KB]  = kb_reply_w.vld;
  assign ctl_byte[CH_KB]  = kb_reply_w.dat;
  assign ctl_push[CH_AUX] = aux_reply_w.vld;
  assign ctl_byte[CH_AUX] = aux_reply_w.dat;

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    ps2h_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .dev_push (dev_push[c]),
      .dev_byte (dev_byte[c]),
      .ctl_push (ctl_push[c]),
      .ctl_byte (ctl_byte[c]),
      .pop      (pop[c]),
      .head     (head[c]),
      .level    (level[c])
    );
  end

  assign kb_level_w  = level[CH_KB];
  assign aux_level_w = level[CH_AUX];

  ps2h_rdsel #(.CW(CW)) u_rdsel (
    .bus_rd    (bus_rd),
    .bus_cmd   (bus_cmd),
    .kb_level  (kb_level_w),
    .aux_level (aux_level_w),
    .kb_head   (head[CH_KB]),
    .aux_head  (head[CH_AUX]),
    .mode      (mode_w),
    .selftest  (selftest_w),
    .cmdflag   (cmdflag_w),
    .status    (status_w),
    .rdata     (bus_rdata),
    .kb_pop    (pop[CH_KB]),
    .aux_pop   (pop[CH_AUX]),
    .kb_irq    (kb_irq),
    .aux_irq   (aux_irq)
  );

  assign kb_tx_valid   = kb_tx_w.vld;
  assign kb_tx_data    = kb_tx_w.dat;
  assign aux_tx_valid  = aux_tx_w.vld;
  assign aux_tx_data   = aux_tx_w.dat;
  assign outp_wr_valid = outp_w.vld;
  assign outp_wr_data  = outp_w.dat;

endmodule

// File: rtl/ps2_hostreg_chk.sv
module ps2_hostreg_chk #(
  parameter int unsigned DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_wr,
  input logic                       bus_cmd,
  input logic                       kb_tx_valid,
  input logic                       aux_tx_valid,
  input logic                       outp_wr_valid,
  input logic                       kb_irq,
  input logic                       aux_irq,
  input logic [7:0]                 status,
  input logic [$clog2(DEPTH+1)-1:0] kb_level,
  input logic [$clog2(DEPTH+1)-1:0] aux_level
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  p_irq_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(kb_irq && aux_irq));

  p_kb_irq_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    kb_irq |-> (kb_level != '0) && status[0] && !status[5]);

  p_aux_irq_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    aux_irq |-> (aux_level != '0) && status[5]);

  p_cmdflag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_cmd) |=> status[3]);

  p_cmdflag_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_cmd) |=> !status[3]);

  p_fixed_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    status[4] && (status[7:6] == 2'b00) && !status[1]);

  p_kbtx_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    kb_tx_valid |-> $past(bus_wr && !bus_cmd));

  p_auxtx_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    aux_tx_valid |-> $past(bus_wr && !bus_cmd));

  p_outp_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    outp_wr_valid |-> $past(bus_wr && !bus_cmd));

  p_one_route_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({kb_tx_valid, aux_tx_valid, outp_wr_valid}));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (kb_level <= CW'(DEPTH)) && (aux_level <= CW'(DEPTH)));

endmodule

bind ps2_hostreg ps2_hostreg_chk #(.DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .bus_wr        (bus_wr),
  .bus_cmd       (bus_cmd),
  .kb_tx_valid   (kb_tx_valid),
  .aux_tx_valid  (aux_tx_valid),
  .outp_wr_valid (outp_wr_valid),
  .kb_irq        (kb_irq),
  .aux_irq       (aux_irq),
  .status        (status_w),
  .kb_level      (kb_level_w),
  .aux_level     (aux_level_w)
);

// File: tb/ps2_hostreg_bench.sv
module ps2_hostreg_bench;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr, bus_rd, bus_cmd;
  logic [7:0] bus_wdata, bus_rdata;
  logic       kb_rx_valid, aux_rx_valid;
  logic [7:0] kb_rx_data, aux_rx_data;
  logic       kb_tx_valid, aux_tx_valid, outp_wr_valid;
  logic [7:0] kb_tx_data, aux_tx_data, outp_wr_data;
  logic       kb_irq, aux_irq;

  int  nchk = 0;
  int  nfail = 0;
  bit  done = 1'b0;
  bit  st_e = 1'b0;
  bit  cf_e = 1'b1;

  always #4 clk = ~clk;

  ps2_hostreg #(.DEPTH(DEPTH)) u_ps2_hostreg (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_cmd(bus_cmd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .kb_rx_valid(kb_rx_valid), .kb_rx_data(kb_rx_data),
    .aux_rx_valid(aux_rx_valid), .aux_rx_data(aux_rx_data),
    .kb_tx_valid(kb_tx_valid), .kb_tx_data(kb_tx_data),
    .aux_tx_valid(aux_tx_valid), .aux_tx_data(aux_tx_data),
    .outp_wr_valid(outp_wr_valid), .outp_wr_data(outp_wr_data),
    .kb_irq(kb_irq), .aux_irq(aux_irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_stat(input bit kbp, input bit auxp);
    return {2'b00, auxp & ~kbp, 1'b1, cf_e, st_e, 1'b0, kbp | auxp};
  endfunction

  function automatic bit is_known(input logic [7:0] c);
    case (c)
      8'h20, 8'h60, 8'hA7, 8'hA8, 8'hA9, 8'hAA, 8'hAB, 8'hAD, 8'hAE,
      8'hC0, 8'hD1, 8'hD2, 8'hD3, 8'hD4: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic bus_write(input bit cmd, input logic [7:0] d);
    bus_wr = 1'b1; bus_cmd = cmd; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    cf_e = cmd;
  endtask

  task automatic bus_read(input bit cmd, output logic [7:0] d);
    bus_rd = 1'b1; bus_cmd = cmd;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic kb_dev(input logic [7:0] b);
    kb_rx_valid = 1'b1; kb_rx_data = b;
    @(negedge clk);
    kb_rx_valid = 1'b0;
  endtask

  task automatic get_mode(output logic [7:0] m);
    bus_write(1'b1, 8'h20);
    bus_read(1'b0, m);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, m;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_cmd = 1'b0; bus_wdata = '0;
    kb_rx_valid = 1'b0; kb_rx_data = '0; aux_rx_valid = 1'b0; aux_rx_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    bus_read(1'b1, r);  check("R1 status", r, 8'h18);
    check("R1 kb_irq", {7'b0, kb_irq}, 8'h00);
    check("R1 aux_irq", {7'b0, aux_irq}, 8'h00);
    get_mode(m);        check("R1 mode", m, 8'h03);
    bus_read(1'b1, r);  check("R1 empty after", r, exp_stat(0, 0));

    // R2/R6/R7 sweep of every mode value
    for (int i = 0; i < 256; i++) begin
      logic [7:0] mv;
      mv = 8'(i);
      bus_write(1'b1, 8'h60);
      bus_write(1'b0, mv);
      bus_write(1'b1, 8'h20);
      check("R7 kb_irq sweep", {7'b0, kb_irq}, {7'b0, mv[0] & ~mv[4]});
      check("R7 aux_irq sweep", {7'b0, aux_irq}, 8'h00);
      bus_read(1'b1, r); check("R6 status kb pend", r, exp_stat(1, 0));
      bus_read(1'b0, r); check("R2 mode reply", r, mv);
    end
    bus_write(1'b1, 8'h60); bus_write(1'b0, 8'h03);

    // R7/R8 priority with both channels
    for (int i = 0; i < 5; i++) begin
      logic [7:0] mv;
      mv = (i == 4) ? 8'h13 : 8'(i);
      bus_write(1'b1, 8'h60); bus_write(1'b0, mv);
      bus_write(1'b1, 8'hD3); bus_write(1'b0, 8'hA0 + 8'(i));
      check("R7 aux_irq alone", {7'b0, aux_irq}, {7'b0, mv[1]});
      check("R7 kb_irq none", {7'b0, kb_irq}, 8'h00);
      bus_read(1'b1, r); check("R6 aux only", r, exp_stat(0, 1));
      kb_dev(8'hB0 + 8'(i));
      check("R7 aux_irq masked by kb", {7'b0, aux_irq}, 8'h00);
      check("R7 kb_irq both", {7'b0, kb_irq}, {7'b0, mv[0] & ~mv[4]});
      bus_read(1'b1, r); check("R6 both pend", r, exp_stat(1, 1));
      bus_read(1'b0, r); check("R8 kb first", r, 8'hB0 + 8'(i));
      check("R7 aux_irq back", {7'b0, aux_irq}, {7'b0, mv[1]});
      bus_read(1'b0, r); check("R8 aux next", r, 8'hA0 + 8'(i));
      bus_read(1'b1, r); check("R6 drained", r, exp_stat(0, 0));
    end
    bus_write(1'b1, 8'h60); bus_write(1'b0, 8'h03);

    // R2 reply commands
    bus_write(1'b1, 8'hAA); st_e = 1'b1;
    bus_read(1'b1, r); check("R2 selftest bit", r, exp_stat(1, 0));
    bus_read(1'b0, r); check("R2 selftest reply", r, 8'h55);
    bus_write(1'b1, 8'hA9); bus_read(1'b0, r); check("R2 aux test", r, 8'h00);
    bus_write(1'b1, 8'hAB); bus_read(1'b0, r); check("R2 kb test", r, 8'h00);
    bus_write(1'b1, 8'hC0); bus_read(1'b0, r); check("R2 input port", r, 8'h80);
    bus_read(1'b1, r); check("R2 empty", r, exp_stat(0, 0));

    // R3 routing of the data write
    bus_write(1'b1, 8'hD1); bus_write(1'b0, 8'h5A);
    check("R3 outp strobe", {7'b0, outp_wr_valid}, 8'h01);
    check("R3 outp data", outp_wr_data, 8'h5A);
    check("R3 no kb_tx", {7'b0, kb_tx_valid}, 8'h00);
    bus_write(1'b0, 8'h77);
    check("R3 latch cleared", {7'b0, kb_tx_valid}, 8'h01);
    check("R3 latch cleared data", kb_tx_data, 8'h77);
    bus_write(1'b1, 8'hD4); bus_write(1'b0, 8'h33);
    check("R3 aux_tx strobe", {7'b0, aux_tx_valid}, 8'h01);
    check("R3 aux_tx data", aux_tx_data, 8'h33);
    check("R3 aux_tx no kb_tx", {7'b0, kb_tx_valid}, 8'h00);
    bus_write(1'b1, 8'hD2); bus_write(1'b0, 8'h44);
    bus_read(1'b1, r); check("R3 kbq status", r, exp_stat(1, 0));
    bus_read(1'b0, r); check("R3 kbq byte", r, 8'h44);
    bus_write(1'b1, 8'hD3); bus_write(1'b0, 8'h66);
    bus_read(1'b1, r); check("R3 auxq status", r, exp_stat(0, 1));
    bus_read(1'b0, r); check("R3 auxq byte", r, 8'h66);

    // R4 plain data writes go to the keyboard device as one-cycle pulses
    for (int i = 0; i < 8; i++) begin
      bus_write(1'b0, 8'(i * 37 + 1));
      check("R4 kb_tx valid", {7'b0, kb_tx_valid}, 8'h01);
      check("R4 kb_tx data", kb_tx_data, 8'(i * 37 + 1));
      @(negedge clk);
      check("R4 kb_tx pulse end", {7'b0, kb_tx_valid}, 8'h00);
    end

    // R5 enable/disable commands
    bus_write(1'b1, 8'hA7); get_mode(m); check("R5 aux off", m, 8'h23);
    bus_write(1'b1, 8'hA8); get_mode(m); check("R5 aux on", m, 8'h03);
    bus_write(1'b1, 8'hAD); get_mode(m); check("R5 kb off", m, 8'h13);
    bus_write(1'b1, 8'hAE); get_mode(m); check("R5 kb on", m, 8'h03);
    kb_dev(8'h12);
    check("R5 irq pending", {7'b0, kb_irq}, 8'h01);
    bus_write(1'b1, 8'hAD);
    check("R5 irq off", {7'b0, kb_irq}, 8'h00);
    bus_write(1'b1, 8'hAE);
    check("R5 irq on", {7'b0, kb_irq}, 8'h01);
    for (int i = 0; i < 3; i++) begin
      bus_read(1'b1, r); check("R8 status read no pop", r, exp_stat(1, 0));
    end
    bus_read(1'b0, r); check("R8 byte kept", r, 8'h12);

    // R9 every unrecognised command is ignored
    for (int c = 0; c < 256; c++) begin
      if (!is_known(8'(c))) begin
        bus_write(1'b1, 8'(c));
        bus_read(1'b1, r); check("R9 status", r, exp_stat(0, 0));
        check("R9 strobes", {5'b0, kb_tx_valid, aux_tx_valid, outp_wr_valid}, 8'h00);
      end
    end
    get_mode(m); check("R9 mode kept", m, 8'h03);
    bus_write(1'b1, 8'h60); bus_write(1'b1, 8'h55); bus_write(1'b0, 8'h41);
    check("R9 latch kept no tx", {7'b0, kb_tx_valid}, 8'h00);
    get_mode(m); check("R9 latch kept mode", m, 8'h41);
    bus_write(1'b1, 8'h60); bus_write(1'b0, 8'h03);

    // R10 capacity, order, drop when full; R8 empty read
    for (int i = 0; i < DEPTH + 3; i++) kb_dev(8'h80 + 8'(i));
    for (int i = 0; i < DEPTH; i++) begin
      bus_read(1'b0, r); check("R10 order", r, 8'h80 + 8'(i));
    end
    bus_read(1'b0, r); check("R8 empty read", r, 8'h00);
    bus_read(1'b1, r); check("R10 empty status", r, exp_stat(0, 0));

    // R11 same-cycle device byte and controller reply
    kb_rx_valid = 1'b1; kb_rx_data = 8'h11;
    bus_write(1'b1, 8'hAA);
    kb_rx_valid = 1'b0;
    bus_read(1'b0, r); check("R11 device first", r, 8'h11);
    bus_read(1'b0, r); check("R11 reply second", r, 8'h55);
    for (int i = 0; i < DEPTH - 1; i++) kb_dev(8'hC0 + 8'(i));
    kb_rx_valid = 1'b1; kb_rx_data = 8'h22;
    bus_write(1'b1, 8'hAB);
    kb_rx_valid = 1'b0;
    for (int i = 0; i < DEPTH - 1; i++) begin
      bus_read(1'b0, r); check("R11 fill order", r, 8'hC0 + 8'(i));
    end
    bus_read(1'b0, r); check("R11 device kept", r, 8'h22);
    bus_read(1'b0, r); check("R11 reply dropped", r, 8'h00);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

endmodule